// File: doc/BRIEF.md
# Hop-Count Priority Deflection Port Allocator

This block sits at the heart of a bufferless deflection router on a two-dimensional mesh. Each cycle up to four packets arrive, one from each mesh-side input register (north, east, south, west). A packet carries an age field, which is the number of hops it has already made, and a preferred output side chosen by an upstream route stage. The router cannot hold a packet back, so the allocator sends every valid packet out on some output side in the same cycle. Older packets are served first. A packet whose preferred side is already claimed is deflected to the least congested free side.

Congestion is measured per side. Each neighbouring router reports how many packets it has handled over its last four cycles. This block computes the same figure for its own router and sends it to the neighbours. Granted packets leave through a registered output stage one cycle after they arrive, with their age advanced by one. On the mesh edge, an unused output side is looped back outside the block to the input on the same side, so a packet deflected there comes back the following cycle.

Top module: `defl_port_alloc`

## Requirements
- R1: While reset is high, and in the first cycle after it, every output valid bit is 0 and the advertised stress value is 0.
- R2: Every input packet that is valid in a cycle appears on exactly one output side in the next cycle, with its payload unchanged. The number of valid outputs equals the number of valid inputs.
- R3: Packets are granted in descending order of hop count. The packet with the highest hop count always receives its preferred side.
- R4: When hop counts are equal, the side with the lower index wins. Side indices are north=0, east=1, south=2, west=3.
- R5: A packet whose preferred side is already claimed goes to the unclaimed side whose neighbour stress input is smallest.
- R6: When several unclaimed sides have the same smallest stress, the one with the lowest side index is chosen.
- R7: Each forwarded packet's hop count is one more than its input value, and saturates at 255.
- R8: The advertised stress equals the total number of valid inputs over the last four clocked cycles, so it ranges from 0 to 16.
- R9: An input whose valid bit is 0 claims no side, whatever its hop count and preference are.
- R10: The preference field uses the same 2-bit side encoding as R4, and output side k carries packets routed to index k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Per-side input packet valid (bit k = side k) |
| in_hop | input | 32 | Per-side 8-bit hop counts, side k at bits 8k+7:8k |
| in_pref | input | 8 | Per-side 2-bit preferred output side |
| in_data | input | 4*DATA_W | Per-side payload |
| nbr_stress | input | 20 | Per-side 5-bit stress reported by neighbour |
| out_valid | output | 4 | Per-side output valid |
| out_hop | output | 32 | Per-side incremented hop counts |
| out_data | output | 4*DATA_W | Per-side payload |
| stress_out | output | 5 | This router's four-cycle packet count |

## Verification
The bench aims at contention. In one case two packets want the same side and the younger one arrives on a lower-index input. A design that serves packets in input order instead of by age would hand the side to the wrong packet. Other cases load all four inputs onto one preferred side with mixed and tied neighbour stresses, which would expose a deflection rule that ignores stress, breaks ties the wrong way, or leaves a packet out. The remaining cases drive hop counts at 254 and 255, which catch a counter that wraps. They also send a high-age packet with its valid bit low, which catches an invalid input that still claims a side, and run a fill-then-drain sequence on the stress history, which catches an off-by-one window length.

// File: rtl/defl_alloc_pkg.sv
package defl_alloc_pkg;

    localparam int NPORT      = 4;
    localparam int PORT_W     = 2;
    localparam int HOP_W      = 8;
    localparam int HIST_LEN   = 4;
    localparam int CNT_W      = $clog2(NPORT + 1);
    localparam int STRESS_MAX = NPORT * HIST_LEN;
    localparam int STRESS_W   = $clog2(STRESS_MAX + 1);

    typedef enum logic [PORT_W-1:0] {
        SIDE_N = 2'd0,
        SIDE_E = 2'd1,
        SIDE_S = 2'd2,
        SIDE_W = 2'd3
    } side_e;

    typedef logic [HOP_W-1:0]    hop_t;
    typedef logic [STRESS_W-1:0] stress_t;
    typedef logic [PORT_W-1:0]   idx_t;

    typedef struct packed {
        logic  valid;
        hop_t  hop;
        side_e pref;
    } hdr_t;

    function automatic hop_t hop_advance(input hop_t h);
        return (h == {HOP_W{1'b1}}) ? h : h + hop_t'(1);
    endfunction

    // true when packet a (on side ia) must be served before packet b (side ib)
    function automatic logic beats(input hop_t ha, input int ia,
                                   input hop_t hb, input int ib);
        return (ha > hb) || ((ha == hb) && (ia < ib));
    endfunction

endpackage

// File: rtl/defl_rank.sv
module defl_rank
    import defl_alloc_pkg::*;
(
    input  hdr_t hdr  [NPORT],
    output idx_t rank [NPORT]
);
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            int cnt;
            cnt = 0;
            for (int j = 0; j < NPORT; j++) begin
                if (j != i && hdr[j].valid && beats(hdr[j].hop, j, hdr[i].hop, i))
                    cnt++;
            end
            rank[i] = idx_t'(cnt);
        end
    end
endmodule

// File: rtl/defl_grant.sv
module defl_grant
    import defl_alloc_pkg::*;
(
    input  hdr_t    hdr    [NPORT],
    input  idx_t    rank   [NPORT],
    input  stress_t stress [NPORT],
    output idx_t    dest   [NPORT]
);
    always_comb begin
        logic [NPORT-1:0] taken;
        logic             hit;
        logic             got;
        idx_t             who;
        idx_t             pick;
        stress_t          best;
        taken = '0;
        for (int i = 0; i < NPORT; i++) dest[i] = '0;
        for (int k = 0; k < NPORT; k++) begin
            hit  = 1'b0;
            who  = '0;
            pick = '0;
            got  = 1'b0;
            best = '0;
            for (int i = 0; i < NPORT; i++) begin
                if (hdr[i].valid && rank[i] == idx_t'(k)) begin
                    hit = 1'b1;
                    who = idx_t'(i);
                end
            end
            if (hit) begin
                if (!taken[hdr[who].pref]) begin
                    pick = hdr[who].pref;
                end else begin
                    for (int p = 0; p < NPORT; p++) begin
                        if (!taken[p] && (!got || stress[p] < best)) begin
                            got  = 1'b1;
                            best = stress[p];
                            pick = idx_t'(p);
                        end
                    end
                end
                taken[pick] = 1'b1;
                dest[who]   = pick;
            end
        end
    end
endmodule

// File: rtl/defl_stress.sv
module defl_stress
    import defl_alloc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] seen,
    output stress_t          level
);
    logic [CNT_W-1:0] hist [HIST_LEN];
    logic [CNT_W-1:0] now_cnt;

    assign now_cnt = CNT_W'($countones(seen));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int h = 0; h < HIST_LEN; h++) hist[h] <= '0;
        end else begin
            hist[0] <= now_cnt;
            for (int h = 1; h < HIST_LEN; h++) hist[h] <= hist[h-1];
        end
    end

    always_comb begin
        int sum;
        sum = 0;
        for (int h = 0; h < HIST_LEN; h++) sum += int'(hist[h]);
        level = (sum > STRESS_MAX) ? stress_t'(STRESS_MAX) : stress_t'(sum);
    end
endmodule

// File: rtl/defl_port_alloc.sv
module defl_port_alloc
    import defl_alloc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NPORT-1:0]           in_valid,
    input  logic [NPORT*HOP_W-1:0]     in_hop,
    input  logic [NPORT*PORT_W-1:0]    in_pref,
    input  logic [NPORT*DATA_W-1:0]    in_data,
    input  logic [NPORT*STRESS_W-1:0]  nbr_stress,
    output logic [NPORT-1:0]           out_valid,
    output logic [NPORT*HOP_W-1:0]     out_hop,
    output logic [NPORT*DATA_W-1:0]    out_data,
    output logic [STRESS_W-1:0]        stress_out
);
    hdr_t              hdr    [NPORT];
    logic [DATA_W-1:0] pay    [NPORT];
    stress_t           stress [NPORT];
    idx_t              rank   [NPORT];
    idx_t              dest   [NPORT];

    logic              nxt_v  [NPORT];
    hop_t              nxt_h  [NPORT];
    logic [DATA_W-1:0] nxt_d  [NPORT];
    logic              q_v    [NPORT];
    hop_t              q_h    [NPORT];
    logic [DATA_W-1:0] q_d    [NPORT];

    for (genvar g = 0; g < NPORT; g++) begin : g_side
        assign hdr[g].valid = in_valid[g];
        assign hdr[g].hop   = in_hop[g*HOP_W +: HOP_W];
        assign hdr[g].pref  = side_e'(in_pref[g*PORT_W +: PORT_W]);
        assign pay[g]       = in_data[g*DATA_W +: DATA_W];
        assign stress[g]    = nbr_stress[g*STRESS_W +: STRESS_W];

        assign out_valid[g]                = q_v[g];
        assign out_hop[g*HOP_W +: HOP_W]   = q_h[g];
        assign out_data[g*DATA_W +: DATA_W] = q_d[g];
    end

    defl_rank u_rank (
        .hdr  (hdr),
        .rank (rank)
    );

    defl_grant u_grant (
        .hdr    (hdr),
        .rank   (rank),
        .stress (stress),
        .dest   (dest)
    );

    defl_stress u_stress (
        .clk   (clk),
        .rst   (rst),
        .seen  (in_valid),
        .level (stress_out)
    );

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            nxt_v[p] = 1'b0;
            nxt_h[p] = '0;
            nxt_d[p] = '0;
            for (int i = 0; i < NPORT; i++) begin
                if (hdr[i].valid && dest[i] == idx_t'(p)) begin
                    nxt_v[p] = 1'b1;
                    nxt_h[p] = hop_advance(hdr[i].hop);
                    nxt_d[p] = pay[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPORT; p++) begin
                q_v[p] <= 1'b0;
                q_h[p] <= '0;
                q_d[p] <= '0;
            end
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                q_v[p] <= nxt_v[p];
                q_h[p] <= nxt_h[p];
                q_d[p] <= nxt_d[p];
            end
        end
    end
endmodule

// File: rtl/defl_port_alloc_chk.sv
module defl_port_alloc_chk
    import defl_alloc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NPORT-1:0]           in_valid,
    input logic [NPORT*HOP_W-1:0]     in_hop,
    input logic [NPORT*PORT_W-1:0]    in_pref,
    input logic [NPORT*DATA_W-1:0]    in_data,
    input logic [NPORT*STRESS_W-1:0]  nbr_stress,
    input logic [NPORT-1:0]           out_valid,
    input logic [NPORT*HOP_W-1:0]     out_hop,
    input logic [NPORT*DATA_W-1:0]    out_data,
    input logic [STRESS_W-1:0]        stress_out
);
    // R2: packets are neither dropped nor duplicated
    a_r2_conserve: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($countones(out_valid) == $countones($past(in_valid))));

    // R9 / R2: no input means no output
    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        (in_valid == '0) |=> (out_valid == '0));

    // R7: forwarded hop count is never zero after the increment
    for (genvar g = 0; g < NPORT; g++) begin : g_hop
        a_r7_hop_nonzero: assert property (@(posedge clk) disable iff (rst)
            out_valid[g] |-> (out_hop[g*HOP_W +: HOP_W] != '0));
    end

    // R8: stress bounded by the window capacity
    a_r8_stress_bound: assert property (@(posedge clk) disable iff (rst)
        int'(stress_out) <= STRESS_MAX);

    // R8: one cycle can add at most one full set of ports
    a_r8_stress_step: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (int'(stress_out) <= int'($past(stress_out)) + NPORT));
endmodule

bind defl_port_alloc defl_port_alloc_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/defl_port_alloc_tb_top.sv
module defl_port_alloc_tb_top;
    localparam int DW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  in_valid;
    logic [31:0] in_hop;
    logic [7:0]  in_pref;
    logic [63:0] in_data;
    logic [19:0] nbr_stress;
    logic [3:0]  out_valid;
    logic [31:0] out_hop;
    logic [63:0] out_data;
    logic [4:0]  stress_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    defl_port_alloc #(.DATA_W(DW)) dut_i (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] tag(input int i);
        return 16'hA000 + 16'(i);
    endfunction

    function automatic int where(input int i);
        for (int p = 0; p < 4; p++)
            if (out_valid[p] && out_data[p*16 +: 16] == tag(i)) return p;
        return -1;
    endfunction

    task automatic clear_in();
        in_valid = '0; in_hop = '0; in_pref = '0; in_data = '0;
    endtask

    task automatic put(input int i, input int hop, input int pref);
        in_valid[i]        = 1'b1;
        in_hop[i*8 +: 8]   = 8'(hop);
        in_pref[i*2 +: 2]  = 2'(pref);
        in_data[i*16 +: 16] = tag(i);
    endtask

    task automatic set_stress(input int n, input int e, input int s, input int w);
        nbr_stress = {5'(w), 5'(s), 5'(e), 5'(n)};
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; clear_in(); set_stress(0, 0, 0, 0);
        repeat (2) @(negedge clk);
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 stress in reset", int'(stress_out), 0);
        rst = 1'b0;
    endtask

    task automatic t_stress_window();
        for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < 4; i++) put(i, 1, i);
            @(negedge clk);
            check("R8 stress fill", int'(stress_out), (c + 1) * 4);
            check("R2 four outputs", $countones(out_valid), 4);
        end
        clear_in();
        @(negedge clk);
        check("R8 stress drain", int'(stress_out), 12);
        put(2, 3, 0);
        @(negedge clk);
        check("R8 stress mix", int'(stress_out), 9);
    endtask

    task automatic t_single();
        clear_in(); set_stress(0, 0, 0, 0);
        put(3, 2, 0);
        @(negedge clk);
        check("R10 west to north", where(3), 0);
        check("R2 single count", $countones(out_valid), 1);
        check("R7 hop 2 to 3", int'(out_hop[7:0]), 3);
    endtask

    task automatic t_age_wins();
        clear_in(); set_stress(3, 0, 1, 2);
        put(0, 5, 1);
        put(2, 9, 1);
        @(negedge clk);
        check("R3 older packet gets east", where(2), 1);
        check("R5 younger deflected to low stress south", where(0), 2);
    endtask

    task automatic t_hop_tie();
        clear_in(); set_stress(0, 0, 0, 0);
        put(1, 7, 2);
        put(3, 7, 2);
        @(negedge clk);
        check("R4 east beats west on tie", where(1), 2);
        check("R6 equal stress picks north", where(3), 0);
    endtask

    task automatic t_full_load();
        clear_in(); set_stress(0, 5, 5, 2);
        for (int i = 0; i < 4; i++) put(i, i + 1, 0);
        @(negedge clk);
        check("R3 oldest west gets north", where(3), 0);
        check("R5 south deflected to west", where(2), 3);
        check("R6 east tie takes east", where(1), 1);
        check("R2 north gets last side", where(0), 2);
    endtask

    task automatic t_saturate();
        clear_in(); set_stress(0, 0, 0, 0);
        put(0, 255, 0);
        put(1, 254, 1);
        put(2, 0, 2);
        @(negedge clk);
        check("R7 255 holds", int'(out_hop[7:0]), 255);
        check("R7 254 to 255", int'(out_hop[15:8]), 255);
        check("R7 0 to 1", int'(out_hop[23:16]), 1);
    endtask

    task automatic t_invalid_ignored();
        clear_in(); set_stress(0, 0, 0, 0);
        in_hop[7:0] = 8'd200; in_pref[1:0] = 2'd2;
        put(1, 1, 2);
        @(negedge clk);
        check("R9 invalid input claims nothing", where(1), 2);
        check("R9 one output only", $countones(out_valid), 1);
    endtask

    initial begin
        clear_in(); set_stress(0, 0, 0, 0);
        t_reset();
        check("R1 first cycle stress", int'(stress_out), 0);
        t_stress_window();
        t_single();
        t_age_wins();
        t_hop_tie();
        t_full_load();
        t_saturate();
        t_invalid_ignored();
        @(negedge clk);
        clear_in();
        @(negedge clk);
        check("R2 idle no output", int'(out_valid), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R2 actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule